// File: doc/BRIEF.md
# Bit-Command GPIO Port with Pin-Change Interrupt

This block is one port of general-purpose pins behind a byte-wide register strobe interface. Software never writes the output latch as a whole byte. Each write to the data address is a command that sets or clears exactly one latch bit, so two agents can change different pins without a read-modify-write race. A read of the same address returns the pin levels seen through a two-flop synchroniser.

Each pin has a two-bit drive mode that turns the latch into an output-enable and output-value pair for the pad. The mode's high bit and low bit are held in two separate byte registers. Each pin also has a Schmitt-select bit that goes straight to the pad. A pin-change detector with a per-pin mask sets a sticky flag. Software can read the flag, clear it, and route it to an active-low interrupt line.

Top module: `gpio_bitport`

## Requirements
- R1: After reset, every pin is input-only (mode-high register reads 0xFF, mode-low register reads 0x00), the latch is all ones, pin_oe is 0, irq_n is 1, and the Schmitt, mask and interrupt-control registers read 0.
- R2: A write to address 0 changes one latch bit: bus_wdata[2:0] selects the pin and bus_wdata[3] is its new value. The change shows on pin_out from the clock edge that takes the write, and every other latch bit keeps its value.
- R3: Bits 7:4 of a write to address 0 have no effect on the latch.
- R4: Each pin's mode is {mode-high[i] at address 1, mode-low[i] at address 2}. Code 0 (quasi-bidirectional) and code 3 (open-drain) assert pin_oe[i] only while the latch bit is 0. Code 1 (push-pull) always asserts it. Code 2 (input-only) never asserts it. pin_out always equals the latch.
- R5: A read of address 0 returns pin_in through two flops: a change made before a rising edge is visible after the second rising edge and not after the first.
- R6: The Schmitt register at address 3 drives schmitt_sel directly and reads back what was written.
- R7: With mask register bit i (address 4) set, a rising or falling change on pin_in[i] sets the triggered flag (bit 0 of address 5) on the third rising edge after the change. A change on a masked-out pin leaves the flag at 0.
- R8: A write to address 5 with bit 0 = 0 clears the flag. Bit 0 = 1 leaves the flag as it was, and software cannot set it. Bit 1 is the interrupt output enable and reads back.
- R9: irq_n is 0 exactly while the flag is set and the output enable is 1.
- R10: If a masked pin change and a flag-clearing write land in the same cycle, the flag is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output value (the latch) |
| pin_oe | output | 8 | Pad output enable |
| schmitt_sel | output | 8 | Per-pin Schmitt input select |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two functions can act on the flag in the same cycle: the pin-change detector, which sets it, and the software clear. The bench toggles a masked pin and counts two rising edges so the edge pulse is live. It then presents a clear write in the cycle in which that edge sets the flag. The flag must read 1 afterwards, and a later lone clear must bring it to 0. This shows that the set won the collision and that the clear path still works.

// File: rtl/gpio_bitport_pkg.sv
package gpio_bitport_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PORT   = 3'd0,
    A_MODEH  = 3'd1,
    A_MODEL  = 3'd2,
    A_SCHMT  = 3'd3,
    A_MASK   = 3'd4,
    A_IRQCTL = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    DRV_QUASI = 2'd0,
    DRV_PUSH  = 2'd1,
    DRV_INPUT = 2'd2,
    DRV_OPEN  = 2'd3
  } drive_mode_e;

  localparam int IRQ_FLAG_BIT = 0;
  localparam int IRQ_EN_BIT   = 1;

endpackage

// File: rtl/gpio_latch_ctl.sv
module gpio_latch_ctl #(
  parameter int NPINS = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic             cmd_val,
  output logic [NPINS-1:0] latch_q
);

  logic [NPINS-1:0] latch_d;
  logic [NPINS-1:0] bit_sel;

  for (genvar i = 0; i < NPINS; i++) begin : g_sel
    assign bit_sel[i] = cmd_vld && (cmd_idx == IDX_W'(i));
  end

  always_comb begin
    latch_d = latch_q;
    for (int i = 0; i < NPINS; i++) begin
      if (bit_sel[i]) latch_d[i] = cmd_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '1;
    else if (cmd_vld) latch_q <= latch_d;
  end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bitport_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  mode_hi_q,
  output logic [NPINS-1:0]  mode_lo_q,
  output logic [NPINS-1:0]  schmitt_q,
  output logic [NPINS-1:0]  mask_q
);

  logic we_hi, we_lo, we_st, we_mk;

  always_comb begin
    we_hi = wr && (addr == A_MODEH);
    we_lo = wr && (addr == A_MODEL);
    we_st = wr && (addr == A_SCHMT);
    we_mk = wr && (addr == A_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_hi_q <= '1;
    else if (we_hi) mode_hi_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_lo_q <= '0;
    else if (we_lo) mode_lo_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) schmitt_q <= '0;
    else if (we_st) schmitt_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (we_mk) mask_q <= wdata;
  end

endmodule

// File: rtl/gpio_drive_dec.sv
module gpio_drive_dec
  import gpio_bitport_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic [NPINS-1:0] mode_hi,
  input  logic [NPINS-1:0] mode_lo,
  input  logic [NPINS-1:0] latch,
  output logic [NPINS-1:0] oe
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    drive_mode_e md;
    assign md = drive_mode_e'({mode_hi[i], mode_lo[i]});
    always_comb begin
      case (md)
        DRV_PUSH:  oe[i] = 1'b1;
        DRV_INPUT: oe[i] = 1'b0;
        DRV_QUASI: oe[i] = ~latch[i];
        DRV_OPEN:  oe[i] = ~latch[i];
        default:   oe[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] mask,
  input  logic             ctl_wr,
  input  logic             ctl_clr,
  input  logic             ctl_en,
  output logic [NPINS-1:0] pin_sync,
  output logic [NPINS-1:0] hit,
  output logic             flag_q,
  output logic             en_q
);

  logic [NPINS-1:0] sync1_q, sync2_q, prev_q;
  logic             flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign pin_sync = sync2_q;
  assign hit      = (sync2_q ^ prev_q) & mask;

  always_comb begin
    flag_d = flag_q;
    if (ctl_wr && ctl_clr) flag_d = 1'b0;
    if (|hit)              flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (ctl_wr) en_q <= ctl_en;
  end

endmodule

// File: rtl/gpio_bitport.sv
module gpio_bitport
  import gpio_bitport_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  schmitt_sel,
  output logic              irq_n
);

  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  logic [1:0]       rst_pipe_q;
  logic             rst_core_n;
  logic [NPINS-1:0] latch_q, mode_hi_q, mode_lo_q, mask_q, pin_sync, hit_vec;
  logic             port_wr, ctl_wr, irq_flag, irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign port_wr = bus_wr && (bus_addr == A_PORT);
  assign ctl_wr  = bus_wr && (bus_addr == A_IRQCTL);

  gpio_latch_ctl #(.NPINS(NPINS), .IDX_W(IDX_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cmd_vld (port_wr),
    .cmd_idx (bus_wdata[IDX_W-1:0]),
    .cmd_val (bus_wdata[IDX_W]),
    .latch_q (latch_q)
  );

  gpio_cfg_regs #(.NPINS(NPINS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .mode_hi_q (mode_hi_q),
    .mode_lo_q (mode_lo_q),
    .schmitt_q (schmitt_sel),
    .mask_q    (mask_q)
  );

  gpio_drive_dec #(.NPINS(NPINS)) u_drv (
    .mode_hi (mode_hi_q),
    .mode_lo (mode_lo_q),
    .latch   (latch_q),
    .oe      (pin_oe)
  );

  gpio_chg_irq #(.NPINS(NPINS)) u_irq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .pin_in   (pin_in),
    .mask     (mask_q),
    .ctl_wr   (ctl_wr),
    .ctl_clr  (~bus_wdata[IRQ_FLAG_BIT]),
    .ctl_en   (bus_wdata[IRQ_EN_BIT]),
    .pin_sync (pin_sync),
    .hit      (hit_vec),
    .flag_q   (irq_flag),
    .en_q     (irq_en)
  );

  assign pin_out = latch_q;
  assign irq_n   = ~(irq_flag & irq_en);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PORT:   bus_rdata = pin_sync;
      A_MODEH:  bus_rdata = mode_hi_q;
      A_MODEL:  bus_rdata = mode_lo_q;
      A_SCHMT:  bus_rdata = schmitt_sel;
      A_MASK:   bus_rdata = mask_q;
      A_IRQCTL: begin
        bus_rdata[IRQ_FLAG_BIT] = irq_flag;
        bus_rdata[IRQ_EN_BIT]   = irq_en;
      end
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_bitport_chk.sv
module gpio_bitport_chk #(
  parameter int NPINS = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq_n,
  input logic [NPINS-1:0] mode_hi,
  input logic [NPINS-1:0] mode_lo,
  input logic [NPINS-1:0] hit,
  input logic             flag,
  input logic             irq_en
);

  logic port_wr;
  assign port_wr = bus_wr && (bus_addr == 3'd0);

  a_r2_target_bit: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> pin_out[$past(bus_wdata[IDX_W-1:0])] == $past(bus_wdata[IDX_W]));

  a_r2_single_change: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> $countones(pin_out ^ $past(pin_out)) <= 1);

  a_r2_hold_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr |=> $stable(pin_out));

  a_r4_input_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_hi & ~mode_lo) & pin_oe) == '0);

  a_r4_push_on: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mode_hi & mode_lo) & ~pin_oe) == '0);

  a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(|hit));

  a_r10_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> flag);

  a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && irq_en) |-> !irq_n);

endmodule

bind gpio_bitport gpio_bitport_chk #(.NPINS(NPINS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq_n     (irq_n),
  .mode_hi   (mode_hi_q),
  .mode_lo   (mode_lo_q),
  .hit       (hit_vec),
  .flag      (irq_flag),
  .irq_en    (irq_en)
);

// File: tb/tb_gpio_bitport.sv
`timescale 1ns/1ps
module tb_gpio_bitport;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic [7:0] schmitt_sel;
  logic       irq_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  gpio_bitport dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .schmitt_sel(schmitt_sel), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  function automatic logic [7:0] model_oe(input logic [7:0] hi, input logic [7:0] lo,
                                          input logic [7:0] lat);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      case ({hi[i], lo[i]})
        2'd1:    r[i] = 1'b1;
        2'd2:    r[i] = 1'b0;
        default: r[i] = ~lat[i];
      endcase
    end
    return r;
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 latch", pin_out, 8'hFF);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    rd(3'd1, d); chk("R1 mode_hi", d, 8'hFF);
    rd(3'd2, d); chk("R1 mode_lo", d, 8'h00);
    rd(3'd3, d); chk("R1 schmitt", d, 8'h00);
    rd(3'd4, d); chk("R1 mask", d, 8'h00);
    rd(3'd5, d); chk("R1 irqctl", d, 8'h00);
  endtask

  task automatic t_bitcmd();
    wr(3'd0, 8'h03); chk("R2 clear bit3", pin_out, 8'hF7);
    wr(3'd0, 8'h0B); chk("R2 set bit3", pin_out, 8'hFF);
    wr(3'd0, 8'h00); chk("R2 clear bit0", pin_out, 8'hFE);
    wr(3'd0, 8'h0F); chk("R2 set bit7", pin_out, 8'hFE);
    wr(3'd0, 8'h07); chk("R2 clear bit7", pin_out, 8'h7E);
    wr(3'd0, 8'h0F); chk("R2 restore bit7", pin_out, 8'hFE);
  endtask

  task automatic t_upper_ignored();
    wr(3'd0, 8'hF5); chk("R3 upper bits ignored", pin_out, 8'hDE);
    wr(3'd0, 8'h7D); chk("R3 upper bits ignored set", pin_out, 8'hFE);
    wr(3'd0, 8'h05); chk("R3 plain clear bit5", pin_out, 8'hDE);
  endtask

  task automatic t_modes();
    logic [7:0] d;
    wr(3'd1, 8'hF0);
    wr(3'd2, 8'hCC);
    rd(3'd1, d); chk("R4 mode_hi readback", d, 8'hF0);
    rd(3'd2, d); chk("R4 mode_lo readback", d, 8'hCC);
    chk("R4 oe mixed", pin_oe, model_oe(8'hF0, 8'hCC, 8'hDE));
    chk("R4 oe literal", pin_oe, 8'h0D);
    wr(3'd0, 8'h07);
    chk("R4 open-drain low", pin_oe, 8'h8D);
    wr(3'd0, 8'h04);
    chk("R4 input-only stays off", pin_oe, 8'h8D);
    chk("R4 out follows latch", pin_out, 8'h4E);
    wr(3'd0, 8'h0A);
    chk("R4 push-pull on high", pin_oe, model_oe(8'hF0, 8'hCC, 8'h4E));
  endtask

  task automatic t_sync();
    logic [7:0] d;
    @(negedge clk); pin_in = 8'hA5;
    @(posedge clk);
    rd(3'd0, d); chk("R5 after one edge", d, 8'h00);
    @(posedge clk);
    rd(3'd0, d); chk("R5 after two edges", d, 8'hA5);
  endtask

  task automatic t_schmitt();
    logic [7:0] d;
    wr(3'd3, 8'h3C);
    chk("R6 schmitt_sel", schmitt_sel, 8'h3C);
    rd(3'd3, d); chk("R6 readback", d, 8'h3C);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(3'd4, 8'h01);
    @(negedge clk); pin_in[1] = ~pin_in[1];
    cycles(5);
    rd(3'd5, d); chk("R7 masked-out pin", d, 8'h00);
    @(negedge clk); pin_in[0] = ~pin_in[0];
    cycles(2);
    rd(3'd5, d); chk("R7 not yet at two edges", d, 8'h00);
    cycles(1);
    rd(3'd5, d); chk("R7 flag on third edge", d, 8'h01);
    chk("R9 disabled irq high", {7'd0, irq_n}, 8'h01);
    wr(3'd5, 8'h03);
    rd(3'd5, d); chk("R8 write one keeps flag", d, 8'h03);
    chk("R9 irq low", {7'd0, irq_n}, 8'h00);
    wr(3'd5, 8'h02);
    rd(3'd5, d); chk("R8 clear flag", d, 8'h02);
    chk("R9 irq released", {7'd0, irq_n}, 8'h01);
    wr(3'd5, 8'h03);
    rd(3'd5, d); chk("R8 cannot set by write", d, 8'h02);
    @(negedge clk); pin_in[0] = ~pin_in[0];
    cycles(4);
    rd(3'd5, d); chk("R7 other edge direction", d, 8'h03);
    wr(3'd5, 8'h00);
    rd(3'd5, d); chk("R8 clear both", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    @(negedge clk); pin_in[0] = ~pin_in[0];
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 8'h02;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    rd(3'd5, d); chk("R10 set wins over clear", d, 8'h03);
    wr(3'd5, 8'h02);
    rd(3'd5, d); chk("R10 later clear works", d, 8'h02);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    cycles(3);
    @(negedge clk); rst_n = 1'b1;
    cycles(3);
    t_reset();
    t_bitcmd();
    t_upper_ignored();
    t_modes();
    t_sync();
    t_schmitt();
    t_irq();
    t_collide();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule